// File: doc/BRIEF.md
# Microcoded Datapath ALU with Post-Shifter

This block is the arithmetic heart of a microprogrammed datapath. Each cycle a microinstruction sets a handful of control lines. Those lines pick how a 32-bit left operand and a 32-bit right operand are combined. The left operand always comes from an internal holding register. The right operand arrives on the shared B bus. The combined value then passes through a small shifter, and the shifted value is driven out as the C bus result.

The operation set is not chosen by an opcode. It is built from several control lines:
- two function-select bits;
- an enable for each operand, which forces that operand to zero when low;
- an invert on the left operand;
- a carry-in to the adder.

The shifter can move the result left by one byte or right by one bit arithmetically. Negative and zero status flags are taken from the ALU output before the shifter. A microsequencer can branch on these flags.

The holding register loads from the C bus when its load strobe is high at a clock edge. To copy the B bus into it, the sequencer adds with the left enable low.

All paths from the operands to the C bus and the flags are combinational. They are valid within the same cycle. No handshake is used: the sequencer owns every cycle and there is no back-pressure.

Top module: `mdp_alu_shift`

## Requirements
- R1: `fsel` selects the core operation: 2'b00 gives A AND B, 2'b01 gives A OR B, 2'b10 gives NOT B, and 2'b11 gives A + B modulo 2^32.
- R2: When `en_left` is low, the left operand is zero before any inversion. When `en_right` is low, the right operand is zero.
- R3: When `inv_left` is high, the gated left operand is bitwise inverted before the operation.
- R4: `carry_in` adds 1 to the sum when `fsel` is 2'b11. For the three logic operations it has no effect.
- R5: When `shl_byte` is high and `sar_bit` is low, `c_bus` is the ALU output shifted left by 8, with bits 7:0 zero.
- R6: When `sar_bit` is high and `shl_byte` is low, `c_bus` is the ALU output shifted right by 1, with bit 31 copied from the ALU output's bit 31.
- R7: When `shl_byte` and `sar_bit` are both high (an illegal combination), `c_bus` is the ALU output unshifted. With both low, the output is also unshifted.
- R8: `neg_flag` equals bit 31 of the ALU output. `zero_flag` is high exactly when all 32 ALU output bits are zero. Both flags are taken before the shifter.
- R9: The holding register resets to zero. It captures `c_bus` at a rising clock edge when `h_load` is high, and otherwise keeps its value.
- R10: The left operand is the holding register. Adding with `en_left` low, `en_right` high, no invert and no carry passes `b_bus` unchanged to `c_bus`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the holding register |
| rst_n | input | 1 | Asynchronous active-low reset |
| b_bus | input | 32 | Right operand from the shared bus |
| fsel | input | 2 | Core function select |
| en_left | input | 1 | Left operand enable |
| en_right | input | 1 | Right operand enable |
| inv_left | input | 1 | Invert gated left operand |
| carry_in | input | 1 | Adder carry-in |
| shl_byte | input | 1 | Shift result left by 8 |
| sar_bit | input | 1 | Shift result right 1, arithmetic |
| h_load | input | 1 | Load holding register from C bus |
| c_bus | output | 32 | Shifted result |
| neg_flag | output | 1 | ALU output bit 31 |
| zero_flag | output | 1 | ALU output all zero |
| h_value | output | 32 | Current holding register contents |

## Verification
On every cycle the assertions check the following:
- the shifter fill and sign-copy rules, and the illegal-combination pass-through;
- the NOT-B result with the right operand disabled;
- agreement between the flags and the C bus when nothing is shifted or when shifting right;
- the B-bus pass-through configuration;
- the holding register's capture and hold behaviour.

Correct addition and carry-in, the logic operations under every enable and invert mix, and carry-in being ignored by logic operations need known operand values. Only the bench scenarios can show these, by comparing against the reference model. The same applies to multi-cycle sequences, where a value loaded into H is reused as the left operand.

// File: rtl/mdp_pkg.sv
package mdp_pkg;
  typedef enum logic [1:0] {
    FN_AND  = 2'b00,
    FN_OR   = 2'b01,
    FN_NOTB = 2'b10,
    FN_ADD  = 2'b11
  } alu_fn_e;
endpackage

// File: rtl/mdp_alu_core.sv
module mdp_alu_core
  import mdp_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] h_opnd,
  input  logic [W-1:0] b_opnd,
  input  alu_fn_e      fn,
  input  logic         en_l,
  input  logic         en_r,
  input  logic         inv_l,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic         neg,
  output logic         zero
);
  localparam int unsigned MSB = W - 1;

  logic [W-1:0] a_gated, a_eff, b_eff, sum;

  // Gate first, then invert: a disabled input with invert gives all ones
  always_comb begin
    a_gated = en_l ? h_opnd : '0;
    a_eff   = inv_l ? ~a_gated : a_gated;
    b_eff   = en_r ? b_opnd : '0;
  end

  assign sum = a_eff + b_eff + {{(W-1){1'b0}}, cin};

  always_comb begin
    unique case (fn)
      FN_AND:  res = a_eff & b_eff;
      FN_OR:   res = a_eff | b_eff;
      FN_NOTB: res = ~b_eff;
      default: res = sum;
    endcase
  end

  assign neg  = res[MSB];
  assign zero = (res == '0);

  AST_NOTB_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (fn == FN_NOTB && !en_r) |-> (res == {W{1'b1}})); // R1
endmodule

// File: rtl/mdp_shifter.sv
module mdp_shifter #(
  parameter int unsigned W     = 32,
  parameter int unsigned SHAMT = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  input  logic         shl,
  input  logic         sar,
  output logic [W-1:0] dout
);
  localparam int unsigned MSB = W - 1;

  logic [W-1:0] left_v, right_v;

  generate
    if (SHAMT == 0) begin : g_noshift
      assign left_v = din;
    end else begin : g_shift
      assign left_v = {din[W-SHAMT-1:0], {SHAMT{1'b0}}};
    end
  endgenerate

  assign right_v = {din[MSB], din[MSB:1]};

  // Illegal combination (both set) falls through to unshifted
  always_comb begin
    unique case ({shl, sar})
      2'b10:   dout = left_v;
      2'b01:   dout = right_v;
      default: dout = din;
    endcase
  end

  AST_SHL_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (shl && !sar) |-> (dout[SHAMT-1:0] == '0)); // R5
  AST_SAR_SIGN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (sar && !shl) |-> (dout[MSB] == din[MSB] && dout[MSB-1] == din[MSB])); // R6
  AST_BOTH_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (sar && shl) |-> (dout == din)); // R7
endmodule

// File: rtl/mdp_hold_reg.sv
module mdp_hold_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end

  AST_H_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (q == $past(d))); // R9
  AST_H_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q)); // R9
endmodule

// File: rtl/mdp_alu_shift.sv
module mdp_alu_shift
  import mdp_pkg::*;
#(
  parameter int unsigned W     = 32,
  parameter int unsigned SHAMT = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] b_bus,
  input  logic [1:0]   fsel,
  input  logic         en_left,
  input  logic         en_right,
  input  logic         inv_left,
  input  logic         carry_in,
  input  logic         shl_byte,
  input  logic         sar_bit,
  input  logic         h_load,
  output logic [W-1:0] c_bus,
  output logic         neg_flag,
  output logic         zero_flag,
  output logic [W-1:0] h_value
);
  localparam int unsigned MSB = W - 1;

  logic [W-1:0] h_q, alu_out;

  mdp_hold_reg #(.W(W)) u_hreg (
    .clk(clk), .rst_n(rst_n), .load(h_load), .d(c_bus), .q(h_q)
  );

  mdp_alu_core #(.W(W)) u_core (
    .clk(clk), .rst_n(rst_n), .h_opnd(h_q), .b_opnd(b_bus),
    .fn(alu_fn_e'(fsel)), .en_l(en_left), .en_r(en_right),
    .inv_l(inv_left), .cin(carry_in),
    .res(alu_out), .neg(neg_flag), .zero(zero_flag)
  );

  mdp_shifter #(.W(W), .SHAMT(SHAMT)) u_shift (
    .clk(clk), .rst_n(rst_n), .din(alu_out), .shl(shl_byte),
    .sar(sar_bit), .dout(c_bus)
  );

  assign h_value = h_q;

  AST_ZERO_UNSHIFTED: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_flag && !shl_byte && !sar_bit) |-> (c_bus == '0)); // R8
  AST_NEG_ON_SAR: assert property (@(posedge clk) disable iff (!rst_n)
    (sar_bit && !shl_byte) |-> (c_bus[MSB] == neg_flag)); // R8
  AST_PASS_B: assert property (@(posedge clk) disable iff (!rst_n)
    (fsel == 2'b11 && !en_left && en_right && !inv_left && !carry_in &&
     !shl_byte && !sar_bit) |-> (c_bus == b_bus)); // R10
endmodule

// File: tb/mdp_alu_shift_tb_top.sv
module mdp_alu_shift_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] b_bus = '0;
  logic [1:0]  fsel = '0;
  logic        en_left = 0, en_right = 0, inv_left = 0, carry_in = 0;
  logic        shl_byte = 0, sar_bit = 0, h_load = 0;
  logic [31:0] c_bus, h_value;
  logic        neg_flag, zero_flag;

  int n_tests = 0;
  int n_fail  = 0;
  logic [31:0] ref_h = '0;
  bit done = 0;

  always #2 clk = ~clk;

  mdp_alu_shift dut_i (
    .clk(clk), .rst_n(rst_n), .b_bus(b_bus), .fsel(fsel),
    .en_left(en_left), .en_right(en_right), .inv_left(inv_left),
    .carry_in(carry_in), .shl_byte(shl_byte), .sar_bit(sar_bit),
    .h_load(h_load), .c_bus(c_bus), .neg_flag(neg_flag),
    .zero_flag(zero_flag), .h_value(h_value)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Behavioural reference: wide integer arithmetic, then truncate
  function automatic logic [31:0] ref_alu(logic [31:0] h, logic [31:0] b,
      logic [1:0] f, bit el, bit er, bit ia, bit ci);
    longint unsigned a, bb, r;
    a  = el ? longint'(h) : 0;
    if (ia) a = a ^ 64'hFFFF_FFFF;
    bb = er ? longint'(b) : 0;
    case (f)
      2'd0: r = a & bb;
      2'd1: r = a | bb;
      2'd2: r = bb ^ 64'hFFFF_FFFF;
      default: r = a + bb + longint'(ci);
    endcase
    return r[31:0];
  endfunction

  function automatic logic [31:0] ref_shift(logic [31:0] v, bit sl, bit sr);
    if (sl && !sr) return v * 32'd256;
    if (sr && !sl) return 32'($signed(v) >>> 1);
    return v;
  endfunction

  task automatic step(string tag, logic [31:0] b, logic [1:0] f, bit el,
      bit er, bit ia, bit ci, bit sl, bit sr, bit ld);
    logic [31:0] ea, ec;
    @(negedge clk);
    b_bus = b; fsel = f; en_left = el; en_right = er; inv_left = ia;
    carry_in = ci; shl_byte = sl; sar_bit = sr; h_load = ld;
    #1;
    ea = ref_alu(ref_h, b, f, el, er, ia, ci);
    ec = ref_shift(ea, sl, sr);
    check({tag, " c_bus"}, c_bus, ec);
    check({tag, " neg R8"}, {31'b0, neg_flag}, {31'b0, ea[31]});
    check({tag, " zero R8"}, {31'b0, zero_flag}, {31'b0, ea == 32'b0});
    @(posedge clk);
    #1;
    if (ld) ref_h = ec;
    check({tag, " h R9"}, h_value, ref_h);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #9;
    check("R9 reset h", h_value, 32'h0);
    rst_n = 1'b1;
    // R10: load H with B through add, left disabled
    step("R10 passB", 32'h8000_00F1, 2'b11, 0, 1, 0, 0, 0, 0, 1);
    step("R1 and",  32'hF0F0_1234, 2'b00, 1, 1, 0, 0, 0, 0, 0);
    step("R1 or",   32'h0F0F_0000, 2'b01, 1, 1, 0, 0, 0, 0, 0);
    step("R1 notb", 32'h1234_5678, 2'b10, 1, 1, 0, 0, 0, 0, 0);
    step("R1 add",  32'h7FFF_FFFF, 2'b11, 1, 1, 0, 0, 0, 0, 0);
    step("R2 enl off", 32'h0000_00FF, 2'b01, 0, 1, 0, 0, 0, 0, 0);
    step("R2 enr off", 32'hFFFF_FFFF, 2'b01, 1, 0, 0, 0, 0, 0, 0);
    step("R2 notb enr off", 32'h5555_5555, 2'b10, 1, 0, 0, 0, 0, 0, 0);
    step("R3 inv", 32'h0000_0000, 2'b11, 1, 1, 1, 0, 0, 0, 0);
    step("R3 inv gated", 32'h0000_0003, 2'b00, 0, 1, 1, 0, 0, 0, 0);
    step("R4 neg via inc", 32'h0000_0005, 2'b11, 1, 0, 1, 1, 0, 0, 0);
    step("R4 inc and", 32'hFFFF_FFFF, 2'b00, 1, 1, 0, 1, 0, 0, 0);
    step("R4 inc or", 32'h0000_0000, 2'b01, 0, 0, 0, 1, 0, 0, 0);
    step("R4 inc notb", 32'h0000_0000, 2'b10, 0, 1, 0, 1, 0, 0, 0);
    step("R8 wrap zero", 32'hFFFF_FFFF, 2'b11, 0, 1, 0, 1, 0, 0, 0);
    step("R5 shl", 32'h8123_4567, 2'b11, 0, 1, 0, 0, 1, 0, 0);
    step("R6 sar neg", 32'h8000_0002, 2'b11, 0, 1, 0, 0, 0, 1, 0);
    step("R6 sar pos", 32'h7000_0003, 2'b11, 0, 1, 0, 0, 0, 1, 0);
    step("R7 both", 32'h8765_4321, 2'b11, 0, 1, 0, 0, 1, 1, 0);
    step("R8 zero before shl", 32'h0100_0000, 2'b11, 0, 1, 0, 0, 1, 0, 0);
    step("R5 load shifted", 32'h00AB_CDEF, 2'b11, 0, 1, 0, 0, 1, 0, 1);
    step("R9 hold", 32'h1111_1111, 2'b01, 1, 1, 0, 0, 0, 0, 0);
    step("R10 h as A", 32'h0000_0001, 2'b11, 1, 1, 0, 0, 0, 0, 0);
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      step("R1 random", $urandom, r[1:0], r[2], r[3], r[4], r[5], r[6],
           r[7], r[8]);
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule